// File: doc/BRIEF.md
# Security-Filtering AXI-Lite to APB Bridge

This block accepts single-beat AXI4-Lite reads and writes and replays each one as an APB transfer to one of up to sixteen peripherals. The address picks the peripheral: the 64 KB window starting at address zero is cut into 4 KB slots, and address bits [15:12] give the slot number. Each slot drives its own select line. A parameter mask says which slots have a peripheral fitted.

APB carries no security attribute, so the bridge does the filtering itself. Each slot has a live security input. A high level marks that peripheral as Secure. When AxPROT[1] is 1 the transaction counts as Non-secure, and when it is 0 the transaction counts as Secure. A Non-secure access to a Secure slot is turned away inside the bridge and no APB cycle takes place. The security inputs are read again for every transaction, so a trusted controller can move a peripheral between worlds at run time without a reset.

Only one transfer is handled at a time. When a write and a read request arrive in the same cycle, the write goes first.

Top module: `apb_secure_bridge`

## Requirements
- R1: While reset is high and in the first cycle after it, awready, wready, arready, bvalid, rvalid, penable and every psel bit are low.
- R2: A permitted access to slot s drives only psel bit s (one-hot value 1<<s) and puts address bits [15:0] on paddr. Slot s is given by address bits [15:12].
- R3: An address with any bit above bit 15 set, or one that falls in a slot not fitted in the populated mask (slot 15 by default), gets DECERR (2'b11). No psel is raised, and reads return zero data.
- R4: A Non-secure access (AxPROT[1]=1) to a slot whose security input is 1 gets SLVERR (2'b10). No psel is raised, and reads return zero data.
- R5: A Secure access (AxPROT[1]=0) to any fitted slot, and a Non-secure access to a slot whose security input is 0, are carried out on APB.
- R6: The security inputs are sampled for each transaction. Changing a bit between two transactions changes the second one's outcome without any reset.
- R7: Each APB transfer has exactly one setup cycle (psel high, penable low), followed by access cycles with penable high. psel, paddr and pwrite stay stable until pready is high.
- R8: With N wait cycles from the peripheral, penable stays high for N+1 cycles, and the AXI response comes only after pready.
- R9: A completed transfer answers OKAY (2'b00), or SLVERR when pslverr is high along with pready. A read returns the prdata sampled with pready.
- R10: When a write request and a read request come in the same cycle, the write goes to APB first. At most one psel bit is ever high.
- R11: bvalid and rvalid, together with their response codes, stay asserted until the master takes them with bready or rready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| slot_secure | input | NUM_SLOTS | Per-slot security input, 1 = Secure |
| awvalid | input | 1 | Write address valid |
| awready | output | 1 | Write address ready |
| awaddr | input | ADDR_W | Write address |
| awprot | input | 3 | Write protection; bit 1 = Non-secure |
| wvalid | input | 1 | Write data valid |
| wready | output | 1 | Write data ready |
| wdata | input | DATA_W | Write data |
| bvalid | output | 1 | Write response valid |
| bready | input | 1 | Write response ready |
| bresp | output | 2 | Write response code |
| arvalid | input | 1 | Read address valid |
| arready | output | 1 | Read address ready |
| araddr | input | ADDR_W | Read address |
| arprot | input | 3 | Read protection; bit 1 = Non-secure |
| rvalid | output | 1 | Read data valid |
| rready | input | 1 | Read data ready |
| rdata | output | DATA_W | Read data |
| rresp | output | 2 | Read response code |
| psel | output | NUM_SLOTS | One-hot APB peripheral selects |
| penable | output | 1 | APB enable (access phase) |
| paddr | output | 16 | APB address inside the 64 KB window |
| pwrite | output | 1 | APB direction, 1 = write |
| pwdata | output | DATA_W | APB write data |
| prdata | input | DATA_W | APB read data |
| pready | input | 1 | APB ready / wait-state control |
| pslverr | input | 1 | APB slave error |

## Verification
Two things can land in the same cycle: a write request and a read request to the same slot. The bench raises awvalid, wvalid and arvalid together. It writes a new value and reads the same slot, then checks that the APB log shows the write transfer before the read, and that the read returns the value just written. The same test also depends on at most one select line being high at a time, so the two transfers never overlap on the bus.

// File: rtl/apb_sec_pkg.sv
package apb_sec_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACCEPT,
    ST_SETUP,
    ST_ACCESS,
    ST_RESP
  } br_state_e;

  localparam logic [1:0] RESP_OKAY   = 2'b00;
  localparam logic [1:0] RESP_SLVERR = 2'b10;
  localparam logic [1:0] RESP_DECERR = 2'b11;
endpackage

// File: rtl/req_arbiter.sv
module req_arbiter #(
  parameter int ADDR_W = 32
) (
  input  logic              aw_req,
  input  logic              ar_req,
  input  logic              use_write,
  input  logic [ADDR_W-1:0] awaddr,
  input  logic [ADDR_W-1:0] araddr,
  input  logic              aw_nonsec,
  input  logic              ar_nonsec,
  output logic              take_write,
  output logic              take_any,
  output logic [ADDR_W-1:0] sel_addr,
  output logic              sel_nonsec
);
  // Write has fixed priority over read when both are pending.
  always_comb begin
    take_write = aw_req;
    take_any   = aw_req | ar_req;
    sel_addr   = use_write ? awaddr : araddr;
    sel_nonsec = use_write ? aw_nonsec : ar_nonsec;
  end
endmodule

// File: rtl/slot_decoder.sv
module slot_decoder #(
  parameter int                 ADDR_W    = 32,
  parameter int                 NUM_SLOTS = 16,
  parameter int                 SLOT_LSB  = 12,
  parameter logic [NUM_SLOTS-1:0] POP_MASK = '1
) (
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 nonsec,
  input  logic [NUM_SLOTS-1:0] secure_vec,
  output logic [NUM_SLOTS-1:0] sel_vec,
  output logic                 dec_err,
  output logic                 sec_err
);
  localparam int SLOT_BITS = $clog2(NUM_SLOTS);
  localparam int WIN_W     = SLOT_LSB + SLOT_BITS;

  logic [SLOT_BITS-1:0] slot;
  logic                 in_window;
  logic                 fitted;

  always_comb begin
    slot      = addr[SLOT_LSB +: SLOT_BITS];
    in_window = (addr[ADDR_W-1:WIN_W] == '0);
    fitted    = POP_MASK[slot];
    dec_err   = !(in_window && fitted);
    sec_err   = !dec_err && nonsec && secure_vec[slot];
    sel_vec   = '0;
    if (!dec_err && !sec_err) sel_vec[slot] = 1'b1;
  end

  always_comb begin
    if (!$isunknown({addr, nonsec, secure_vec})) begin
      assert_refused_no_sel_R3: assert (!((dec_err || sec_err) && (sel_vec != '0)))
        else $error("refused access still selects a slot");
    end
  end
endmodule

// File: rtl/bridge_ctrl.sv
module bridge_ctrl
  import apb_sec_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  parameter int PADDR_W   = 16,
  parameter int DATA_W    = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 take_write,
  input  logic                 take_any,
  output logic                 use_write,
  input  logic [PADDR_W-1:0]   cap_addr,
  input  logic [NUM_SLOTS-1:0] sel_vec,
  input  logic                 dec_err,
  input  logic                 sec_err,
  input  logic [DATA_W-1:0]    wdata,
  output logic                 awready,
  output logic                 wready,
  output logic                 arready,
  output logic                 bvalid,
  input  logic                 bready,
  output logic [1:0]           bresp,
  output logic                 rvalid,
  input  logic                 rready,
  output logic [DATA_W-1:0]    rdata,
  output logic [1:0]           rresp,
  output logic [NUM_SLOTS-1:0] psel,
  output logic                 penable,
  output logic [PADDR_W-1:0]   paddr,
  output logic                 pwrite,
  output logic [DATA_W-1:0]    pwdata,
  input  logic [DATA_W-1:0]    prdata,
  input  logic                 pready,
  input  logic                 pslverr
);
  br_state_e state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      use_write <= 1'b0;
      awready   <= 1'b0;
      wready    <= 1'b0;
      arready   <= 1'b0;
      bvalid    <= 1'b0;
      bresp     <= RESP_OKAY;
      rvalid    <= 1'b0;
      rresp     <= RESP_OKAY;
      rdata     <= '0;
      psel      <= '0;
      penable   <= 1'b0;
      paddr     <= '0;
      pwrite    <= 1'b0;
      pwdata    <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (take_any) begin
            use_write <= take_write;
            awready   <= take_write;
            wready    <= take_write;
            arready   <= !take_write;
            state     <= ST_ACCEPT;
          end
        end
        ST_ACCEPT: begin
          awready <= 1'b0;
          wready  <= 1'b0;
          arready <= 1'b0;
          if (dec_err || sec_err) begin
            if (use_write) begin
              bvalid <= 1'b1;
              bresp  <= dec_err ? RESP_DECERR : RESP_SLVERR;
            end else begin
              rvalid <= 1'b1;
              rresp  <= dec_err ? RESP_DECERR : RESP_SLVERR;
              rdata  <= '0;
            end
            state <= ST_RESP;
          end else begin
            psel   <= sel_vec;
            paddr  <= cap_addr;
            pwrite <= use_write;
            pwdata <= wdata;
            state  <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          penable <= 1'b1;
          state   <= ST_ACCESS;
        end
        ST_ACCESS: begin
          if (pready) begin
            psel    <= '0;
            penable <= 1'b0;
            if (use_write) begin
              bvalid <= 1'b1;
              bresp  <= pslverr ? RESP_SLVERR : RESP_OKAY;
            end else begin
              rvalid <= 1'b1;
              rresp  <= pslverr ? RESP_SLVERR : RESP_OKAY;
              rdata  <= prdata;
            end
            state <= ST_RESP;
          end
        end
        ST_RESP: begin
          if (bvalid && bready) begin
            bvalid <= 1'b0;
            state  <= ST_IDLE;
          end
          if (rvalid && rready) begin
            rvalid <= 1'b0;
            state  <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_setup_once_R7: assert property (@(posedge clk) disable iff (rst)
    ((psel != '0) && !penable) |=> (penable && $stable(psel)))
    else $error("setup phase not followed by access");

  assert_access_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (penable && !pready) |=> (penable && $stable(paddr) && $stable(pwrite) && $stable(psel)))
    else $error("APB signals moved during wait");

  assert_enable_has_sel_R7: assert property (@(posedge clk) disable iff (rst)
    penable |-> (psel != '0))
    else $error("penable without select");

  assert_single_sel_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(psel))
    else $error("more than one select high");

  assert_refused_no_apb_R4: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_ACCEPT) && (dec_err || sec_err)) |=> (psel == '0))
    else $error("refused access reached APB");

  assert_b_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (bvalid && !bready) |=> (bvalid && $stable(bresp)))
    else $error("write response dropped early");

  assert_r_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (rvalid && !rready) |=> (rvalid && $stable(rresp) && $stable(rdata)))
    else $error("read response dropped early");
endmodule

// File: rtl/apb_secure_bridge.sv
module apb_secure_bridge #(
  parameter int                   ADDR_W    = 32,
  parameter int                   DATA_W    = 32,
  parameter int                   NUM_SLOTS = 16,
  parameter int                   SLOT_LSB  = 12,
  parameter logic [NUM_SLOTS-1:0] POP_MASK  = 16'h7FFF,
  localparam int                  PADDR_W   = SLOT_LSB + $clog2(NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_SLOTS-1:0] slot_secure,
  input  logic                 awvalid,
  output logic                 awready,
  input  logic [ADDR_W-1:0]    awaddr,
  input  logic [2:0]           awprot,
  input  logic                 wvalid,
  output logic                 wready,
  input  logic [DATA_W-1:0]    wdata,
  output logic                 bvalid,
  input  logic                 bready,
  output logic [1:0]           bresp,
  input  logic                 arvalid,
  output logic                 arready,
  input  logic [ADDR_W-1:0]    araddr,
  input  logic [2:0]           arprot,
  output logic                 rvalid,
  input  logic                 rready,
  output logic [DATA_W-1:0]    rdata,
  output logic [1:0]           rresp,
  output logic [NUM_SLOTS-1:0] psel,
  output logic                 penable,
  output logic [PADDR_W-1:0]   paddr,
  output logic                 pwrite,
  output logic [DATA_W-1:0]    pwdata,
  input  logic [DATA_W-1:0]    prdata,
  input  logic                 pready,
  input  logic                 pslverr
);
  logic                 take_write, take_any, use_write;
  logic [ADDR_W-1:0]    sel_addr;
  logic                 sel_nonsec;
  logic [NUM_SLOTS-1:0] sel_vec;
  logic                 dec_err, sec_err;
  logic                 prot_unused;

  assign prot_unused = ^{awprot[2], awprot[0], arprot[2], arprot[0]};

  req_arbiter #(.ADDR_W(ADDR_W)) u_arb (
    .aw_req     (awvalid && wvalid),
    .ar_req     (arvalid),
    .use_write  (use_write),
    .awaddr     (awaddr),
    .araddr     (araddr),
    .aw_nonsec  (awprot[1]),
    .ar_nonsec  (arprot[1]),
    .take_write (take_write),
    .take_any   (take_any),
    .sel_addr   (sel_addr),
    .sel_nonsec (sel_nonsec)
  );

  slot_decoder #(
    .ADDR_W    (ADDR_W),
    .NUM_SLOTS (NUM_SLOTS),
    .SLOT_LSB  (SLOT_LSB),
    .POP_MASK  (POP_MASK)
  ) u_dec (
    .addr       (sel_addr),
    .nonsec     (sel_nonsec),
    .secure_vec (slot_secure),
    .sel_vec    (sel_vec),
    .dec_err    (dec_err),
    .sec_err    (sec_err)
  );

  bridge_ctrl #(
    .NUM_SLOTS (NUM_SLOTS),
    .PADDR_W   (PADDR_W),
    .DATA_W    (DATA_W)
  ) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .take_write (take_write),
    .take_any   (take_any),
    .use_write  (use_write),
    .cap_addr   (sel_addr[PADDR_W-1:0]),
    .sel_vec    (sel_vec),
    .dec_err    (dec_err),
    .sec_err    (sec_err),
    .wdata      (wdata),
    .awready    (awready),
    .wready     (wready),
    .arready    (arready),
    .bvalid     (bvalid),
    .bready     (bready),
    .bresp      (bresp),
    .rvalid     (rvalid),
    .rready     (rready),
    .rdata      (rdata),
    .rresp      (rresp),
    .psel       (psel),
    .penable    (penable),
    .paddr      (paddr),
    .pwrite     (pwrite),
    .pwdata     (pwdata),
    .prdata     (prdata),
    .pready     (pready),
    .pslverr    (pslverr)
  );

  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> (!awready && !wready && !arready && !bvalid && !rvalid && !penable && (psel == '0)))
    else $error("outputs active right after reset");
endmodule

// File: tb/apb_secure_bridge_test.sv
`timescale 1ns/1ps
module apb_secure_bridge_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] slot_secure = 16'h0000;
  logic        awvalid = 0, wvalid = 0, arvalid = 0, bready = 1, rready = 1;
  logic [31:0] awaddr = 0, araddr = 0, wdata = 0;
  logic [2:0]  awprot = 0, arprot = 0;
  logic        awready, wready, arready, bvalid, rvalid, penable, pwrite;
  logic [1:0]  bresp, rresp;
  logic [31:0] rdata, pwdata, prdata;
  logic [15:0] psel, paddr;
  logic        pready, pslverr;

  int checks = 0, failures = 0;

  apb_secure_bridge uut (
    .clk(clk), .rst(rst), .slot_secure(slot_secure),
    .awvalid(awvalid), .awready(awready), .awaddr(awaddr), .awprot(awprot),
    .wvalid(wvalid), .wready(wready), .wdata(wdata),
    .bvalid(bvalid), .bready(bready), .bresp(bresp),
    .arvalid(arvalid), .arready(arready), .araddr(araddr), .arprot(arprot),
    .rvalid(rvalid), .rready(rready), .rdata(rdata), .rresp(rresp),
    .psel(psel), .penable(penable), .paddr(paddr), .pwrite(pwrite),
    .pwdata(pwdata), .prdata(prdata), .pready(pready), .pslverr(pslverr)
  );

  always #4 clk = ~clk;

  // APB peripheral model plus transfer monitor
  logic [31:0] mem [16];
  int          wait_cfg = 0;
  logic        err_en = 0;
  int          wcnt = 0, setup_cnt = 0, pen_cnt = 0;
  int          xfer_cnt = 0, last_setup = 0, last_pen = 0;
  logic [15:0] last_psel = 0, last_paddr = 0;
  logic [7:0]  order_log = 0;

  assign pready  = penable && (wcnt == wait_cfg);
  assign pslverr = pready && err_en;
  assign prdata  = mem[paddr[15:12]];

  initial for (int i = 0; i < 16; i++) mem[i] = 32'h0;

  always @(posedge clk) begin
    if (penable && pready) begin
      if (pwrite) mem[paddr[15:12]] <= pwdata;
      wcnt       <= 0;
      xfer_cnt   <= xfer_cnt + 1;
      last_psel  <= psel;
      last_paddr <= paddr;
      last_setup <= setup_cnt;
      last_pen   <= pen_cnt + 1;
      setup_cnt  <= 0;
      pen_cnt    <= 0;
      order_log  <= {order_log[6:0], pwrite};
    end else begin
      if (penable) begin
        wcnt    <= wcnt + 1;
        pen_cnt <= pen_cnt + 1;
      end
      if ((psel != 0) && !penable) setup_cnt <= setup_cnt + 1;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic do_write(input logic [31:0] a, input logic [2:0] p,
                          input logic [31:0] d, output logic [1:0] resp);
    awaddr = a; awprot = p; wdata = d; awvalid = 1; wvalid = 1;
    for (int n = 0; n < 50 && !awready; n++) @(negedge clk);
    @(negedge clk);
    awvalid = 0; wvalid = 0;
    for (int n = 0; n < 100 && !bvalid; n++) @(negedge clk);
    resp = bvalid ? bresp : 2'bxx;
    @(negedge clk);
  endtask

  task automatic do_read(input logic [31:0] a, input logic [2:0] p,
                         output logic [31:0] d, output logic [1:0] resp);
    araddr = a; arprot = p; arvalid = 1;
    for (int n = 0; n < 50 && !arready; n++) @(negedge clk);
    @(negedge clk);
    arvalid = 0;
    for (int n = 0; n < 100 && !rvalid; n++) @(negedge clk);
    resp = rvalid ? rresp : 2'bxx;
    d = rdata;
    @(negedge clk);
  endtask

  task automatic t_reset;
    check(!awready && !wready && !arready && !bvalid && !rvalid && !penable && psel == 0,
          "R1", "idle outputs after reset",
          {awready, wready, arready, bvalid, rvalid, penable, psel}, 0);
  endtask

  task automatic t_basic;
    logic [1:0] r; logic [31:0] d; int x0;
    x0 = xfer_cnt;
    do_write(32'h0000_3010, 3'b000, 32'hCAFE_0003, r);
    check(r == 2'b00, "R5", "secure write okay", r, 0);
    check(xfer_cnt == x0 + 1 && last_psel == 16'h0008, "R2", "psel for slot 3", last_psel, 16'h0008);
    check(last_paddr == 16'h3010, "R2", "paddr", last_paddr, 16'h3010);
    check(last_setup == 1 && last_pen == 1, "R7", "setup/access cycles", {last_setup[15:0], last_pen[15:0]}, 32'h0001_0001);
    do_read(32'h0000_3010, 3'b000, d, r);
    check(r == 2'b00 && d == 32'hCAFE_0003, "R9", "read back slot 3", d, 32'hCAFE_0003);
  endtask

  task automatic t_waits;
    logic [1:0] r; logic [31:0] d;
    wait_cfg = 3;
    do_write(32'h0000_5000, 3'b010, 32'h5555_AAAA, r);
    check(r == 2'b00 && last_pen == 4, "R8", "write with 3 waits, penable cycles", last_pen, 4);
    do_read(32'h0000_5000, 3'b010, d, r);
    check(d == 32'h5555_AAAA && last_pen == 4 && last_setup == 1, "R8", "read with 3 waits", d, 32'h5555_AAAA);
    wait_cfg = 0;
  endtask

  task automatic t_security;
    logic [1:0] r; logic [31:0] d; int x0;
    slot_secure = 16'h0004;
    do_write(32'h0000_2000, 3'b000, 32'h1111_2222, r);
    check(r == 2'b00, "R5", "secure access to secure slot", r, 0);
    x0 = xfer_cnt;
    do_write(32'h0000_2000, 3'b010, 32'hDEAD_BEEF, r);
    check(r == 2'b10 && xfer_cnt == x0, "R4", "non-secure write refused", r, 2'b10);
    do_read(32'h0000_2000, 3'b010, d, r);
    check(r == 2'b10 && d == 0 && xfer_cnt == x0, "R4", "non-secure read refused, zero data", d, 0);
    do_read(32'h0000_2000, 3'b000, d, r);
    check(d == 32'h1111_2222, "R4", "refused write left peripheral untouched", d, 32'h1111_2222);
  endtask

  task automatic t_live;
    logic [1:0] r; logic [31:0] d;
    slot_secure = 16'h0000;
    do_write(32'h0000_2004, 3'b010, 32'h7777_0000, r);
    check(r == 2'b00 && last_psel == 16'h0004, "R6", "slot switched to non-secure", r, 0);
    slot_secure = 16'h0004;
    do_read(32'h0000_2004, 3'b010, d, r);
    check(r == 2'b10 && d == 0, "R6", "slot switched back to secure", r, 2'b10);
  endtask

  task automatic t_decode;
    logic [1:0] r; logic [31:0] d; int x0;
    x0 = xfer_cnt;
    do_read(32'h0001_3000, 3'b000, d, r);
    check(r == 2'b11 && d == 0, "R3", "outside window DECERR", r, 2'b11);
    do_write(32'h0000_F000, 3'b000, 32'h1, r);
    check(r == 2'b11, "R3", "unpopulated slot DECERR", r, 2'b11);
    check(xfer_cnt == x0, "R3", "no APB cycle on decode error", xfer_cnt, x0);
  endtask

  task automatic t_slverr;
    logic [1:0] r; logic [31:0] d;
    err_en = 1;
    do_read(32'h0000_3010, 3'b000, d, r);
    check(r == 2'b10, "R9", "pslverr maps to SLVERR", r, 2'b10);
    err_en = 0;
  endtask

  task automatic t_collide;
    bit got_b = 0, got_r = 0;
    logic [1:0] br = 2'bxx, rr = 2'bxx;
    logic [31:0] rd = 0;
    bit aw_done = 0, ar_done = 0;
    mem[4] = 32'h0;
    awaddr = 32'h0000_4000; awprot = 0; wdata = 32'h0000_00A5;
    araddr = 32'h0000_4000; arprot = 0;
    awvalid = 1; wvalid = 1; arvalid = 1;
    for (int n = 0; n < 200 && !(got_b && got_r); n++) begin
      @(negedge clk);
      if (aw_done) begin awvalid = 0; wvalid = 0; end
      if (ar_done) arvalid = 0;
      if (awready) aw_done = 1;
      if (arready) ar_done = 1;
      if (bvalid) begin got_b = 1; br = bresp; end
      if (rvalid) begin got_r = 1; rr = rresp; rd = rdata; end
    end
    awvalid = 0; wvalid = 0; arvalid = 0;
    @(negedge clk);
    check(order_log[1:0] == 2'b10, "R10", "write transfer before read", order_log[1:0], 2'b10);
    check(got_b && got_r && br == 0 && rr == 0 && rd == 32'hA5, "R10", "read sees same-cycle write", rd, 32'hA5);
  endtask

  task automatic t_hold;
    logic [1:0] r;
    bready = 0;
    awaddr = 32'h0000_1000; awprot = 0; wdata = 32'h9; awvalid = 1; wvalid = 1;
    for (int n = 0; n < 50 && !awready; n++) @(negedge clk);
    @(negedge clk);
    awvalid = 0; wvalid = 0;
    for (int n = 0; n < 100 && !bvalid; n++) @(negedge clk);
    repeat (4) @(negedge clk);
    check(bvalid && bresp == 2'b00, "R11", "bvalid held while bready low", bvalid, 1);
    bready = 1;
    @(negedge clk);
    check(!bvalid, "R11", "bvalid drops after handshake", bvalid, 0);
    r = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_basic();
    t_waits();
    t_security();
    t_live();
    t_decode();
    t_slverr();
    t_collide();
    t_hold();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #400000;
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule